// File: doc/BRIEF.md
# DMA Channel Interrupt Status, Enable and Clear Unit

This unit gathers single-cycle event pulses from a DMA transfer/event channel pair into a sticky status register. Software selects which status bits may raise an interrupt through an enable register. It acknowledges events by writing ones to a separate clear register. The enabled subset of status, the cause, drives either a level-sensitive wired interrupt line or a one-cycle message pulse that carries the cause vector. A mode register picks which of the two is used.

A small register port gives access at fixed offsets. The status register is at 0x100, the clear register at 0x108, the enable register at 0x110 and the interrupt mode register at 0x004. Reads are combinational. Writes take effect on the next rising clock edge. A separate output flags any enabled error cause, whatever the interrupt mode.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset, the status, enable and mode registers read 0, and irq_o, msg_valid_o and err_any_o are low.
- R2: A pulse on an event input sets its status bit on the next clock edge, at these positions: completion 0, event write response error 1, descriptor read error 9, data read error 10, data write error 11, invalid descriptor 14, channel reset done 16.
- R3: Status bits are sticky. Writing a 1 to a bit of the clear register (0x108) clears that status bit. Writing 0 to a bit has no effect. Writes to the status offset (0x100) change nothing.
- R4: An event that arrives in the same cycle as a clear of the same bit leaves the bit set.
- R5: The enable register (0x110) stores only the seven defined bit positions (mask 0x14E03). Every other bit reads 0.
- R6: In wired mode (mode bit 0 set), irq_o is high exactly while status AND enable is non-zero, and it falls when the last enabled bit is cleared or masked.
- R7: In message mode (mode low nibble 0000), irq_o stays low. msg_valid_o is high for one cycle in the cycle after any cause bit newly rises, and msg_cause_o then equals status AND enable.
- R8: When the mode low nibble is non-zero with bit 0 clear, neither irq_o nor msg_valid_o asserts.
- R9: err_any_o is high whenever status AND enable includes any of bits 1, 9, 10, 11 or 14, in every mode. Completion and reset-done causes do not raise it.
- R10: The mode register (0x004) stores its low 4 bits, and higher bits read 0. The clear offset and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| evt_eob_i | input | 1 | End-of-block completion pulse |
| evt_ev_wr_err_i | input | 1 | Event write response error pulse |
| evt_desc_rd_err_i | input | 1 | Descriptor read response error pulse |
| evt_data_rd_err_i | input | 1 | Data read error pulse |
| evt_data_wr_err_i | input | 1 | Data write error pulse |
| evt_bad_desc_i | input | 1 | Invalid descriptor pulse |
| evt_rst_done_i | input | 1 | Channel reset completed pulse |
| irq_o | output | 1 | Wired level interrupt |
| msg_valid_o | output | 1 | Message interrupt pulse |
| msg_cause_o | output | 32 | Cause vector sent with the message pulse |
| err_any_o | output | 1 | Any enabled error cause pending |

## Verification
A hardware event and a software clear of the same status bit can fall in the same clock edge. The set must win. The bench provokes this by pulsing the completion input in the same cycle as a write of 1 to that bit of the clear register. It then reads status back and expects the bit still set. A following clear with no event present must empty it. The bench also changes the mode while a cause is already pending, and it expects no message pulse from that change alone.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 12;

  localparam int unsigned POS_EOB       = 0;
  localparam int unsigned POS_EV_WR_ERR = 1;
  localparam int unsigned POS_DESC_RD   = 9;
  localparam int unsigned POS_DATA_RD   = 10;
  localparam int unsigned POS_DATA_WR   = 11;
  localparam int unsigned POS_BAD_DESC  = 14;
  localparam int unsigned POS_RST_DONE  = 16;
  localparam int unsigned NUM_EVT       = 7;

  localparam logic [AW-1:0] OFF_MODE   = 12'h004;
  localparam logic [AW-1:0] OFF_STATUS = 12'h100;
  localparam logic [AW-1:0] OFF_CLEAR  = 12'h108;
  localparam logic [AW-1:0] OFF_ENABLE = 12'h110;

  localparam logic [DW-1:0] ERR_MASK =
      (DW'(1) << POS_EV_WR_ERR) | (DW'(1) << POS_DESC_RD) | (DW'(1) << POS_DATA_RD) |
      (DW'(1) << POS_DATA_WR)   | (DW'(1) << POS_BAD_DESC);
  localparam logic [DW-1:0] DEF_MASK =
      ERR_MASK | (DW'(1) << POS_EOB) | (DW'(1) << POS_RST_DONE);

  typedef enum logic [1:0] {MODE_MSG, MODE_WIRED, MODE_OFF} irq_mode_e;
endpackage

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
  import dma_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] evt_i,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] enable_o,
  output logic [3:0]    mode_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] status_q, enable_q;
  logic [3:0]    mode_q;
  logic [DW-1:0] clr_mask;

  assign clr_mask = (wr_i && addr_i == OFF_CLEAR) ? (wdata_i & DEF_MASK) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      enable_q <= '0;
      mode_q   <= '0;
    end else begin
      // set has priority over clear
      status_q <= (status_q & ~clr_mask) | (evt_i & DEF_MASK);
      if (wr_i && addr_i == OFF_ENABLE) enable_q <= wdata_i & DEF_MASK;
      if (wr_i && addr_i == OFF_MODE)   mode_q   <= wdata_i[3:0];
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_STATUS: rdata_o = status_q;
      OFF_ENABLE: rdata_o = enable_q;
      OFF_MODE:   rdata_o = {{(DW-4){1'b0}}, mode_q};
      default:    rdata_o = '0;
    endcase
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign mode_o   = mode_q;
endmodule

// File: rtl/dma_irq_out.sv
module dma_irq_out
  import dma_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] cause_i,
  input  logic [3:0]    mode_i,
  output logic          irq_o,
  output logic          msg_valid_o,
  output logic [DW-1:0] msg_cause_o,
  output logic          err_any_o
);
  irq_mode_e     mode;
  logic [DW-1:0] cause_prev_q;

  always_comb begin
    if (mode_i[0])           mode = MODE_WIRED;
    else if (mode_i == 4'h0) mode = MODE_MSG;
    else                     mode = MODE_OFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_prev_q <= '0;
    else         cause_prev_q <= cause_i;
  end

  assign irq_o       = (mode == MODE_WIRED) && (|cause_i);
  assign msg_valid_o = (mode == MODE_MSG) && (|(cause_i & ~cause_prev_q));
  assign msg_cause_o = cause_i;
  assign err_any_o   = |(cause_i & ERR_MASK);
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic [11:0]   reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          evt_eob_i,
  input  logic          evt_ev_wr_err_i,
  input  logic          evt_desc_rd_err_i,
  input  logic          evt_data_rd_err_i,
  input  logic          evt_data_wr_err_i,
  input  logic          evt_bad_desc_i,
  input  logic          evt_rst_done_i,
  output logic          irq_o,
  output logic          msg_valid_o,
  output logic [31:0]   msg_cause_o,
  output logic          err_any_o
);
  localparam int unsigned EVT_POS [NUM_EVT] = '{POS_EOB, POS_EV_WR_ERR, POS_DESC_RD,
      POS_DATA_RD, POS_DATA_WR, POS_BAD_DESC, POS_RST_DONE};

  logic [NUM_EVT-1:0] evt_pins;
  logic [DW-1:0]      evt_vec, status_w, enable_w, cause_w;
  logic [3:0]         mode_w;

  assign evt_pins = {evt_rst_done_i, evt_bad_desc_i, evt_data_wr_err_i, evt_data_rd_err_i,
                     evt_desc_rd_err_i, evt_ev_wr_err_i, evt_eob_i};

  always_comb begin
    evt_vec = '0;
    for (int i = 0; i < NUM_EVT; i++) evt_vec[EVT_POS[i]] = evt_pins[i];
  end

  dma_irq_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .evt_i    (evt_vec),
    .status_o (status_w),
    .enable_o (enable_w),
    .mode_o   (mode_w),
    .rdata_o  (reg_rdata_o)
  );

  assign cause_w = status_w & enable_w;

  dma_irq_out u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cause_i     (cause_w),
    .mode_i      (mode_w),
    .irq_o       (irq_o),
    .msg_valid_o (msg_valid_o),
    .msg_cause_o (msg_cause_o),
    .err_any_o   (err_any_o)
  );
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
module dma_irq_ctrl_chk
  import dma_irq_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_wr_i,
  input logic [11:0]   reg_addr_i,
  input logic          evt_rst_done_i,
  input logic [DW-1:0] status_i,
  input logic [DW-1:0] enable_i,
  input logic [3:0]    mode_i,
  input logic          irq_o,
  input logic          msg_valid_o,
  input logic          err_any_o
);
  logic clr_wr;
  assign clr_wr = reg_wr_i && (reg_addr_i == OFF_CLEAR);

  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_wr |=> ((status_i & $past(status_i)) == $past(status_i)));           // R3
  AST_RST_DONE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_rst_done_i |=> status_i[POS_RST_DONE]);                                // R2
  AST_ENABLE_DEFINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i & ~DEF_MASK) == '0);                                             // R5
  AST_MSG_LINE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'h0) |-> !irq_o);                                              // R7
  AST_MSG_ONLY_MSG_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> (mode_i == 4'h0));                                         // R8
  AST_ERR_NEEDS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_any_o |-> ((status_i & enable_i) != '0));                              // R9
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .reg_wr_i       (reg_wr_i),
  .reg_addr_i     (reg_addr_i),
  .evt_rst_done_i (evt_rst_done_i),
  .status_i       (status_w),
  .enable_i       (enable_w),
  .mode_i         (mode_w),
  .irq_o          (irq_o),
  .msg_valid_o    (msg_valid_o),
  .err_any_o      (err_any_o)
);

// File: tb/dma_irq_ctrl_test.sv
`timescale 1ns/1ps
module dma_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [6:0]  ev = '0;
  logic        irq, msg_valid, err_any;
  logic [31:0] msg_cause;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  localparam int POS [7] = '{0, 1, 9, 10, 11, 14, 16};
  localparam logic [31:0] ERRM = 32'h0000_4E02;

  always #2.5 clk = ~clk;

  dma_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .evt_eob_i(ev[0]), .evt_ev_wr_err_i(ev[1]), .evt_desc_rd_err_i(ev[2]),
    .evt_data_rd_err_i(ev[3]), .evt_data_wr_err_i(ev[4]), .evt_bad_desc_i(ev[5]),
    .evt_rst_done_i(ev[6]), .irq_o(irq), .msg_valid_o(msg_valid),
    .msg_cause_o(msg_cause), .err_any_o(err_any));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(int idx);
    @(negedge clk); ev[idx] = 1'b1;
    @(negedge clk); ev = '0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    rd(12'h100, v); chk("R1 status", v, 0);
    rd(12'h110, v); chk("R1 enable", v, 0);
    rd(12'h004, v); chk("R1 mode", v, 0);
    chk("R1 outputs", {irq, msg_valid, err_any}, 0);
    // R5, R10
    wr(12'h110, 32'hFFFF_FFFF);
    rd(12'h110, v); chk("R5 enable mask", v, 32'h0001_4E03);
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004, v); chk("R10 mode width", v, 32'hF);
    rd(12'h108, v); chk("R10 clear reads 0", v, 0);
    rd(12'h200, v); chk("R10 unmapped", v, 0);
    wr(12'h004, 32'h1);
    // R2 R3 R6 R9 sweep over every event
    for (int i = 0; i < 7; i++) begin
      logic [31:0] b;
      b = 32'h1 << POS[i];
      pulse(i);
      rd(12'h100, v); chk("R2 status bit", v, b);
      chk("R6 irq set", irq, 1);
      chk("R9 err_any", err_any, (b & ERRM) != 0);
      wr(12'h108, ~b);
      rd(12'h100, v); chk("R3 zero-write no effect", v, b);
      wr(12'h100, 32'h0);
      rd(12'h100, v); chk("R3 status write ignored", v, b);
      repeat (2) @(negedge clk);
      rd(12'h100, v); chk("R3 sticky", v, b);
      wr(12'h108, b);
      rd(12'h100, v); chk("R3 cleared", v, 0);
      chk("R6 irq drops", irq, 0);
    end
    // R4 set wins over clear
    pulse(0);
    @(negedge clk); ev[0] = 1'b1; reg_wr = 1'b1; reg_addr = 12'h108; reg_wdata = 32'h1;
    @(negedge clk); ev = '0; reg_wr = 1'b0;
    rd(12'h100, v); chk("R4 set beats clear", v, 32'h1);
    wr(12'h108, 32'h1);
    rd(12'h100, v); chk("R4 later clear", v, 0);
    // R6 masking
    pulse(3);
    wr(12'h110, 32'h0);
    chk("R6 masked irq", irq, 0);
    chk("R9 masked err", err_any, 0);
    wr(12'h110, 32'hFFFF_FFFF);
    chk("R6 unmasked irq", irq, 1);
    // R8 mode sweep with pending cause
    for (int m = 0; m < 16; m++) begin
      wr(12'h004, m);
      chk("R8 irq by mode", irq, m[0]);
      chk("R8 no msg on mode change", msg_valid, 0);
      chk("R9 err in all modes", err_any, 1);
    end
    wr(12'h108, 32'hFFFF_FFFF);
    // R7 message mode
    wr(12'h004, 32'h0);
    pulse(0);
    chk("R7 msg pulse", msg_valid, 1);
    chk("R7 msg cause", msg_cause, 32'h1);
    chk("R7 line low", irq, 0);
    @(negedge clk);
    chk("R7 single cycle", msg_valid, 0);
    pulse(3);
    chk("R7 second pulse", msg_valid, 1);
    chk("R7 second cause", msg_cause, 32'h0000_0401);
    chk("R9 err in msg mode", err_any, 1);
    @(negedge clk);
    chk("R7 second single", msg_valid, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule